// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive-buffer entries kept in system memory. Software programs four 16-bit pointers (ring start, ring end, read pointer and write pointer) plus a shared upper address half. A fetch command makes the block read one entry over a 16-bit memory read port. An entry is four words. The block loads a 32-bit buffer base address and a 32-bit buffer word count from the entry, and then moves the read pointer to the next entry.

After the read pointer advances, it is compared with the ring end. On a match it is reloaded from the ring start. If the pointer then lands on the write pointer, the ring is out of resources and a sticky exhausted flag is raised. Software clears the flag by writing a one to it, and that write also starts a fresh fetch. The entry layout is either packed 16-bit or 32-bit, selected by a static mode input. The 32-bit layout doubles every spacing.

Top module: `rx_ring_fetcher`

## Requirements
- R1: After synchronous reset, every pointer, the upper address, both buffer outputs, busy, done, exhausted and mem_req are zero.
- R2: Writes use reg_wr_sel codes 0 start, 1 end, 2 read pointer, 3 write pointer, 4 upper address. The four pointers store the data with bit 0 forced to zero. The upper address stores all 16 bits.
- R3: Writing reg_wr_sel 6 with data bit 0 set while idle starts a fetch of exactly four words. Word k is read at {upper, base + k*S}, where S is 2 bytes in narrow mode and 4 bytes when wide_mode is 1. mem_req is held high with mem_addr stable until mem_ready is seen, and a word is taken on a clock edge where mem_req and mem_ready are both high.
- R4: At completion buf_addr becomes {word1, word0} and buf_words becomes {word3, word2}.
- R5: busy rises on the edge that accepts the command and falls on the edge that takes the last word. done is high for exactly the one cycle following that edge.
- R6: At completion the read pointer becomes the base (the read pointer when the fetch started) plus 8 in narrow mode or 16 in wide mode.
- R7: If the advanced pointer equals the ring end, the read pointer is set to the ring start instead.
- R8: If the final read pointer equals the write pointer, exhausted is set. It stays set until cleared.
- R9: Writing reg_wr_sel 5 with data bit 0 set while exhausted is 1 clears exhausted and starts one fetch. The same write when exhausted is 0 does nothing, and a write with bit 0 clear does nothing.
- R10: A fetch command or flag clear that arrives while busy starts no extra reads. A command write with data bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the 32-bit entry layout |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select code |
| reg_wr_data | input | 16 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ready | input | 1 | Memory read data valid / request accepted |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| exhausted | output | 1 | Sticky ring-exhausted flag |
| buf_addr | output | 32 | Loaded buffer base address |
| buf_words | output | 32 | Loaded buffer word count |
| ring_start | output | 16 | Ring start pointer |
| ring_end | output | 16 | Ring end pointer |
| rd_ptr | output | 16 | Read pointer |
| wr_ptr | output | 16 | Write pointer |
| upper_addr | output | 16 | Upper address half |

## Verification
A wrong word index or stride shows up on mem_addr during the same fetch, and shows up in the buf_addr and buf_words values in the cycle after the last word is taken. A bad base capture or bad wrap decision appears on rd_ptr at that same edge. The exhausted flag responds to that pointer on the same edge, so a wrong compare is visible one cycle after completion. A launch that is not gated by busy shows up as more than four accepted reads for one command.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int RXR_WORDS = 4;

  typedef enum logic [2:0] {
    SEL_START  = 3'd0,
    SEL_END    = 3'd1,
    SEL_RDPTR  = 3'd2,
    SEL_WRPTR  = 3'd3,
    SEL_UPPER  = 3'd4,
    SEL_STATUS = 3'd5,
    SEL_CMD    = 3'd6
  } rxr_sel_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_READ = 1'b1
  } rxr_fsm_e;
endpackage

// File: rtl/rxr_ptr_regs.sv
module rxr_ptr_regs #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             commit,
  input  logic [PTR_W-1:0] commit_ptr,
  input  logic             commit_exh,
  output logic [PTR_W-1:0] start_q,
  output logic [PTR_W-1:0] end_q,
  output logic [PTR_W-1:0] rd_q,
  output logic [PTR_W-1:0] wr_q,
  output logic [PTR_W-1:0] upper_q,
  output logic             exh_q,
  output logic             clear_hit
);
  import rxr_pkg::*;

  localparam logic [PTR_W-1:0] EVEN_MASK = ~{{(PTR_W-1){1'b0}}, 1'b1};

  rxr_sel_e sel;
  assign sel = rxr_sel_e'(wr_sel);

  // write-one-to-clear only acts on a flag that is currently set
  assign clear_hit = wr_en && (sel == SEL_STATUS) && wr_data[0] && exh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      upper_q <= '0;
      exh_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_START: start_q <= wr_data & EVEN_MASK;
          SEL_END:   end_q   <= wr_data & EVEN_MASK;
          SEL_RDPTR: rd_q    <= wr_data & EVEN_MASK;
          SEL_WRPTR: wr_q    <= wr_data & EVEN_MASK;
          SEL_UPPER: upper_q <= wr_data;
          default: ;
        endcase
      end
      // the engine's pointer update wins over a same-cycle software write
      if (commit) rd_q <= commit_ptr;
      if (clear_hit) exh_q <= 1'b0;
      if (commit && commit_exh) exh_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxr_ptr_advance.sv
module rxr_ptr_advance #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] base,
  input  logic             wide,
  input  logic [PTR_W-1:0] ring_start,
  input  logic [PTR_W-1:0] ring_end,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] next_ptr,
  output logic             hit_exh
);
  import rxr_pkg::*;

  localparam logic [PTR_W-1:0] ENTRY_NARROW = PTR_W'(2 * RXR_WORDS);
  localparam logic [PTR_W-1:0] ENTRY_WIDE   = PTR_W'(4 * RXR_WORDS);

  logic [PTR_W-1:0] stepped;

  always_comb begin
    stepped  = base + (wide ? ENTRY_WIDE : ENTRY_NARROW);
    next_ptr = (stepped == ring_end) ? ring_start : stepped;
    hit_exh  = (next_ptr == wr_ptr);
  end
endmodule

// File: rtl/rxr_fetch_eng.sv
module rxr_fetch_eng #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               wide,
  input  logic [PTR_W-1:0]   rd_ptr,
  input  logic [PTR_W-1:0]   upper,
  input  logic               mem_ready,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_req,
  output logic [2*PTR_W-1:0] mem_addr,
  output logic               busy,
  output logic               done,
  output logic [PTR_W-1:0]   base_q,
  output logic               wide_q,
  output logic               commit,
  output logic [2*DATA_W-1:0] buf_addr,
  output logic [2*DATA_W-1:0] buf_words
);
  import rxr_pkg::*;

  localparam int              IDX_W  = $clog2(RXR_WORDS);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(RXR_WORDS - 1);
  localparam logic [PTR_W-1:0] STEP_N = PTR_W'(2);
  localparam logic [PTR_W-1:0] STEP_W = PTR_W'(4);

  rxr_fsm_e         state;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] word_q [RXR_WORDS-1];
  logic [DATA_W-1:0] cur_word [RXR_WORDS];
  logic             take;

  assign take   = (state == FS_READ) && mem_ready;
  assign commit = take && (idx == LAST);

  genvar k;
  generate
    for (k = 0; k < RXR_WORDS; k++) begin : g_word
      if (k == RXR_WORDS - 1) begin : g_last
        assign cur_word[k] = mem_rdata;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (rst) word_q[k] <= '0;
          else if (take && idx == IDX_W'(k)) word_q[k] <= mem_rdata;
        end
        assign cur_word[k] = word_q[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      idx       <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      base_q    <= '0;
      wide_q    <= 1'b0;
      buf_addr  <= '0;
      buf_words <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (launch) begin
            state    <= FS_READ;
            idx      <= '0;
            base_q   <= rd_ptr;
            wide_q   <= wide;
            mem_req  <= 1'b1;
            mem_addr <= {upper, rd_ptr};
            busy     <= 1'b1;
          end
        end
        FS_READ: begin
          if (mem_ready) begin
            if (idx == LAST) begin
              state     <= FS_IDLE;
              mem_req   <= 1'b0;
              busy      <= 1'b0;
              done      <= 1'b1;
              buf_addr  <= {cur_word[1], cur_word[0]};
              buf_words <= {cur_word[3], cur_word[2]};
            end else begin
              idx <= idx + 1'b1;
              mem_addr[PTR_W-1:0] <= mem_addr[PTR_W-1:0] + (wide_q ? STEP_W : STEP_N);
            end
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_fetcher.sv
module rx_ring_fetcher #(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                reg_wr_en,
  input  logic [2:0]          reg_wr_sel,
  input  logic [PTR_W-1:0]    reg_wr_data,
  output logic                mem_req,
  output logic [2*PTR_W-1:0]  mem_addr,
  input  logic                mem_ready,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic                exhausted,
  output logic [2*DATA_W-1:0] buf_addr,
  output logic [2*DATA_W-1:0] buf_words,
  output logic [PTR_W-1:0]    ring_start,
  output logic [PTR_W-1:0]    ring_end,
  output logic [PTR_W-1:0]    rd_ptr,
  output logic [PTR_W-1:0]    wr_ptr,
  output logic [PTR_W-1:0]    upper_addr
);
  import rxr_pkg::*;

  logic             clear_hit;
  logic             cmd_hit;
  logic             launch;
  logic             commit;
  logic [PTR_W-1:0] base_q;
  logic             wide_q;
  logic [PTR_W-1:0] next_ptr;
  logic             hit_exh;

  assign cmd_hit = reg_wr_en && (reg_wr_sel == SEL_CMD) && reg_wr_data[0];
  assign launch  = !busy && (cmd_hit || clear_hit);

  rxr_ptr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wr_sel     (reg_wr_sel),
    .wr_data    (reg_wr_data),
    .commit     (commit),
    .commit_ptr (next_ptr),
    .commit_exh (hit_exh),
    .start_q    (ring_start),
    .end_q      (ring_end),
    .rd_q       (rd_ptr),
    .wr_q       (wr_ptr),
    .upper_q    (upper_addr),
    .exh_q      (exhausted),
    .clear_hit  (clear_hit)
  );

  rxr_ptr_advance #(.PTR_W(PTR_W)) u_adv (
    .base       (base_q),
    .wide       (wide_q),
    .ring_start (ring_start),
    .ring_end   (ring_end),
    .wr_ptr     (wr_ptr),
    .next_ptr   (next_ptr),
    .hit_exh    (hit_exh)
  );

  rxr_fetch_eng #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .wide      (wide_mode),
    .rd_ptr    (rd_ptr),
    .upper     (upper_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .done      (done),
    .base_q    (base_q),
    .wide_q    (wide_q),
    .commit    (commit),
    .buf_addr  (buf_addr),
    .buf_words (buf_words)
  );
endmodule

// File: rtl/rx_ring_fetcher_chk.sv
module rx_ring_fetcher_chk #(
  parameter int PTR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr_en,
  input logic [2:0]         reg_wr_sel,
  input logic [PTR_W-1:0]   reg_wr_data,
  input logic               mem_req,
  input logic               mem_ready,
  input logic [2*PTR_W-1:0] mem_addr,
  input logic               busy,
  input logic               done,
  input logic               exhausted,
  input logic [PTR_W-1:0]   rd_ptr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R3
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R5
  AST_RDPTR_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(reg_wr_en && reg_wr_sel == 3'd2)) |=> $stable(rd_ptr)); // R6
  AST_EXH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (exhausted && !(reg_wr_en && reg_wr_sel == 3'd5 && reg_wr_data[0])) |=> exhausted); // R8
endmodule

bind rx_ring_fetcher rx_ring_fetcher_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_sel  (reg_wr_sel),
  .reg_wr_data (reg_wr_data),
  .mem_req     (mem_req),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .busy        (busy),
  .done        (done),
  .exhausted   (exhausted),
  .rd_ptr      (rd_ptr)
);

// File: tb/rx_ring_fetcher_tb.sv
`timescale 1ns/1ps
module rx_ring_fetcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = 3'd0;
  logic [15:0] reg_wr_data = 16'd0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = 16'd0;
  logic        busy, done, exhausted;
  logic [31:0] buf_addr, buf_words;
  logic [15:0] ring_start, ring_end, rd_ptr, wr_ptr, upper_addr;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wait_cnt = 0;
  int n_reads = 0;
  logic [31:0] cur_addr = 32'd0;
  logic [31:0] addr_log [64];

  always #2 clk = ~clk;

  rx_ring_fetcher u_dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .exhausted(exhausted),
    .buf_addr(buf_addr), .buf_words(buf_words),
    .ring_start(ring_start), .ring_end(ring_end), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .upper_addr(upper_addr)
  );

  function automatic logic [15:0] memval(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C5A;
  endfunction

  // memory model: answers at the falling edge, ready lasts one cycle per word
  always @(negedge clk) begin
    if (mem_ready) begin
      addr_log[n_reads % 64] = cur_addr;
      n_reads = n_reads + 1;
      mem_ready = 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        cur_addr = mem_addr;
        mem_rdata = memval(mem_addr);
        mem_ready = 1'b1;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (done) break;
    end
    chk("R5", "done pulse", {31'd0, done}, 32'd1);
    chk("R5", "busy low at done", {31'd0, busy}, 32'd0);
  endtask

  // runs a fetch that is already launched and checks the entry contents
  task automatic check_entry(input string req, input logic [31:0] a, input int s, input int r0);
    logic [31:0] e_addr, e_words;
    wait_done();
    chk("R3", "read count", n_reads - r0, 32'd4);
    for (int k = 0; k < 4; k++)
      chk(req, "word address", addr_log[(r0 + k) % 64], a + 32'(k * s));
    e_addr  = {memval(a + 32'(s)), memval(a)};
    e_words = {memval(a + 32'(3 * s)), memval(a + 32'(2 * s))};
    chk("R4", "buf_addr", buf_addr, e_addr);
    chk("R4", "buf_words", buf_words, e_words);
    @(negedge clk); #1;
    chk("R5", "done drops", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "rd_ptr", {16'd0, rd_ptr}, 32'd0);
    chk("R1", "start/end", {ring_start, ring_end}, 32'd0);
    chk("R1", "wr/upper", {wr_ptr, upper_addr}, 32'd0);
    chk("R1", "buf_addr", buf_addr, 32'd0);
    chk("R1", "buf_words", buf_words, 32'd0);
    chk("R1", "flags", {28'd0, busy, done, exhausted, mem_req}, 32'd0);
  endtask

  task automatic t_regs();
    wr(3'd0, 16'h1001);
    wr(3'd1, 16'h2003);
    wr(3'd2, 16'h3005);
    wr(3'd3, 16'h4007);
    wr(3'd4, 16'hABCD);
    chk("R2", "start masked", {16'd0, ring_start}, 32'h1000);
    chk("R2", "end masked", {16'd0, ring_end}, 32'h2002);
    chk("R2", "rd masked", {16'd0, rd_ptr}, 32'h3004);
    chk("R2", "wr masked", {16'd0, wr_ptr}, 32'h4006);
    chk("R2", "upper full", {16'd0, upper_addr}, 32'hABCD);
  endtask

  task automatic t_narrow();
    int r0;
    wr(3'd0, 16'h0100); wr(3'd1, 16'h0140); wr(3'd3, 16'h0180);
    wr(3'd4, 16'h0012); wr(3'd2, 16'h0100);
    r0 = n_reads;
    wr(3'd6, 16'h0001);
    chk("R5", "busy after command", {31'd0, busy}, 32'd1);
    check_entry("R3", 32'h0012_0100, 2, r0);
    chk("R6", "narrow advance", {16'd0, rd_ptr}, 32'h0108);
    chk("R8", "no exhaust", {31'd0, exhausted}, 32'd0);
  endtask

  task automatic t_wrap();
    int r0;
    wr(3'd2, 16'h0138);
    r0 = n_reads;
    wr(3'd6, 16'h0001);
    check_entry("R3", 32'h0012_0138, 2, r0);
    chk("R7", "wrap to start", {16'd0, rd_ptr}, 32'h0100);
    chk("R7", "no exhaust on wrap", {31'd0, exhausted}, 32'd0);
  endtask

  task automatic t_exhaust();
    int r0;
    wr(3'd3, 16'h0100); wr(3'd2, 16'h0138);
    r0 = n_reads;
    wr(3'd6, 16'h0001);
    check_entry("R3", 32'h0012_0138, 2, r0);
    chk("R8", "wrapped ptr", {16'd0, rd_ptr}, 32'h0100);
    chk("R8", "exhausted set", {31'd0, exhausted}, 32'd1);
    idle(5);
    chk("R8", "exhausted sticky", {31'd0, exhausted}, 32'd1);
    r0 = n_reads;
    wr(3'd5, 16'h0000);
    idle(8);
    chk("R9", "clear with bit0=0 keeps flag", {31'd0, exhausted}, 32'd1);
    chk("R9", "clear with bit0=0 no reads", n_reads - r0, 32'd0);
    wr(3'd5, 16'h0001);
    chk("R9", "flag cleared", {31'd0, exhausted}, 32'd0);
    chk("R9", "clear launches fetch", {31'd0, busy}, 32'd1);
    check_entry("R9", 32'h0012_0100, 2, r0);
    chk("R9", "pointer after relaunch", {16'd0, rd_ptr}, 32'h0108);
    r0 = n_reads;
    wr(3'd5, 16'h0001);
    idle(8);
    chk("R9", "clear while clear: no reads", n_reads - r0, 32'd0);
    chk("R9", "clear while clear: ptr", {16'd0, rd_ptr}, 32'h0108);
  endtask

  task automatic t_wide();
    int r0;
    wide_mode = 1'b1;
    wr(3'd1, 16'h0300); wr(3'd2, 16'h0200);
    r0 = n_reads;
    wr(3'd6, 16'h0001);
    check_entry("R3", 32'h0012_0200, 4, r0);
    chk("R6", "wide advance", {16'd0, rd_ptr}, 32'h0210);
    wide_mode = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int r0;
    lat = 3;
    r0 = n_reads;
    wr(3'd6, 16'h0000);
    idle(8);
    chk("R10", "command bit0=0 no reads", n_reads - r0, 32'd0);
    wr(3'd2, 16'h0100);
    wr(3'd6, 16'h0001);
    wr(3'd6, 16'h0001);
    chk("R10", "still busy", {31'd0, busy}, 32'd1);
    check_entry("R10", 32'h0012_0100, 2, r0);
    idle(20);
    chk("R10", "no second fetch", n_reads - r0, 32'd4);
    chk("R10", "single advance", {16'd0, rd_ptr}, 32'h0108);
    lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    idle(1);
    t_reset();
    t_regs();
    t_narrow();
    t_wrap();
    t_exhaust();
    t_wide();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule